// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the requesting side's address-phase generator for a pipelined system bus. It takes a burst request made of a start address, a burst kind and a transfer size, and it produces the transfer-type code, the address, the kind and the size for every address phase of that burst. A burst is handled as one logical transfer with a single opening phase. After that phase, each address is derived from the one before it. Incrementing kinds add the transfer size to the address. Wrapping kinds fold the address back inside a window whose size is the beat count times the transfer size, with the window aligned to its own size.

The surrounding master uses the sequencer in two ways. It drives a data-source readiness flag, and when that flag is low the sequencer issues pause phases, which keep the burst open without counting as beats. It also passes the bus ready and error-response signals straight in. While ready is low, every output holds its value. If an error response arrives in its first cycle, the rest of the burst is dropped. A one-cycle completion pulse marks each burst that ends normally.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and after its release, the transfer-type output is idle (2'b00), and the completion pulse is low until the first burst ends.
- R2: Transfer-type codes are: idle 2'b00, pause 2'b01, start 2'b10, continue 2'b11. The first phase of a burst is start, and it carries the requested address, kind and size. Every later beat is continue.
- R3: Burst kind codes are: 3'b000 single, 3'b001 open-length increment, 3'b011/3'b101/3'b111 increment by 4/8/16 beats. For the incrementing kinds, each beat address is the previous one plus 2**size bytes, where size is the 3-bit size code.
- R4: Kind codes 3'b010/3'b100/3'b110 wrap over 4/8/16 beats. Each address stays inside the window of beats*2**size bytes that is aligned to that width and holds the start address. Past the window's top, the address returns to the window's base.
- R5: When the data source is not ready at the point where the next beat would be issued, a pause phase is issued instead. Its address is already the next beat's address. When the source becomes ready, the same address is reissued as continue. Pause phases are not counted as beats.
- R6: While bus ready is low and no error is signalled, all outputs hold their values, and a new request is not accepted.
- R7: A fixed-length burst issues exactly its number of beats. On the edge that accepts the last beat, the type returns to idle and the completion pulse is high for one cycle.
- R8: An open-length increment burst keeps issuing continue beats while the request stays asserted. It goes idle with a completion pulse on the first accepting edge after the request drops.
- R9: An error response seen together with ready low forces idle at the next edge. The burst is abandoned without a completion pulse.
- R10: A single-kind request produces one start phase, followed by idle with a completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present; for open-length kind, held to continue |
| req_addr | input | AW | Start address of the requested burst |
| req_kind | input | 3 | Requested burst kind code |
| req_size | input | 3 | Requested transfer size code (bytes = 2**code) |
| src_ready | input | 1 | Internal data source can supply the next beat |
| bus_ready | input | 1 | Bus ready; high completes the current phase |
| bus_err | input | 1 | Error response from the addressed target |
| trans_o | output | 2 | Transfer-type code of the current address phase |
| addr_o | output | AW | Address of the current address phase |
| kind_o | output | 3 | Burst kind of the current burst |
| size_o | output | 3 | Transfer size of the current burst |
| done_o | output | 1 | One-cycle pulse after a burst finishes normally |

## Verification
The case hardest to reach from the ports is a pause phase and a bus stall that occur in the same burst. The address must then be advanced exactly once, and the pause must not be counted as a beat. To get there, the stimulus first drops the source-ready flag right after the start phase, which yields several pause phases. It then restores the flag and counts the continue beats up to the completion pulse. A separate scenario drops bus ready while source-ready and the request both change, to confirm that nothing moves. The wrap arithmetic is checked at two sizes with starts in the middle of the window, and a bench-side model computes the expected address with a modulo on the window offset rather than with a mask.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE  = 2'b00,
    TR_PAUSE = 2'b01,
    TR_START = 2'b10,
    TR_CONT  = 2'b11
  } trans_e;

  localparam logic [2:0] BK_SINGLE = 3'b000;
  localparam logic [2:0] BK_INCR   = 3'b001;
  localparam logic [2:0] BK_WRAP4  = 3'b010;
  localparam logic [2:0] BK_INCR4  = 3'b011;
  localparam logic [2:0] BK_WRAP8  = 3'b100;
  localparam logic [2:0] BK_INCR8  = 3'b101;
  localparam logic [2:0] BK_WRAP16 = 3'b110;
  localparam logic [2:0] BK_INCR16 = 3'b111;

  // Number of beats in a fixed-length kind; zero marks open length.
  function automatic logic [4:0] beats_of(input logic [2:0] kind);
    case (kind)
      BK_SINGLE:           beats_of = 5'd1;
      BK_INCR:             beats_of = 5'd0;
      BK_WRAP4, BK_INCR4:  beats_of = 5'd4;
      BK_WRAP8, BK_INCR8:  beats_of = 5'd8;
      default:             beats_of = 5'd16;
    endcase
  endfunction

  function automatic logic kind_wraps(input logic [2:0] kind);
    kind_wraps = (kind != BK_SINGLE) && !kind[0];
  endfunction

  function automatic logic kind_open(input logic [2:0] kind);
    kind_open = (kind == BK_INCR);
  endfunction

endpackage

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [2:0]    kind,
  input  logic [2:0]    size,
  output logic [AW-1:0] nxt_addr,
  output logic          wrap_taken
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] step;
  logic [AW-1:0] span;
  logic [AW-1:0] mask;
  logic [AW-1:0] lin;
  logic          wraps;

  always_comb begin
    step  = ONE << size;
    span  = AW'(beats_of(kind)) << size;
    mask  = span - ONE;
    lin   = cur_addr + step;
    wraps = kind_wraps(kind);
    if (wraps) begin
      nxt_addr   = (base_addr & ~mask) | (lin & mask);
      wrap_taken = ((lin & ~mask) != (base_addr & ~mask));
    end else begin
      nxt_addr   = lin;
      wrap_taken = 1'b0;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  input  logic [2:0]    kind,
  output logic [CW-1:0] count,
  output logic          last_beat
);
  logic [CW-1:0] len;

  always_comb begin
    len       = CW'(beats_of(kind));
    last_beat = bump && !kind_open(kind) && ((count + CW'(1)) == len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (bump)   count <= count + CW'(1);
  end

  // R7: a fixed-length burst never counts past its own length
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !kind_open(kind) |-> (count <= len));

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_kind,
  input  logic [2:0]    req_size,
  input  logic          src_ready,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [AW-1:0] nxt_addr,
  input  logic          wrap_taken,
  input  logic          last_beat,
  output logic          beat_acc,
  output logic          ctr_clear,
  output logic [1:0]    trans_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] base_o,
  output logic [2:0]    kind_o,
  output logic [2:0]    size_o,
  output logic          done_o
);
  trans_e        trans_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] base_q;
  logic [2:0]    kind_q;
  logic [2:0]    size_q;
  logic          done_q;

  logic err_cut;
  logic in_burst;
  logic open_end;
  logic finish;

  always_comb begin
    in_burst  = (trans_q != TR_IDLE);
    beat_acc  = bus_ready && ((trans_q == TR_START) || (trans_q == TR_CONT));
    err_cut   = bus_err && !bus_ready;
    open_end  = kind_open(kind_q) && !req_valid;
    finish    = bus_ready && in_burst && (last_beat || open_end);
    ctr_clear = bus_ready && !in_burst && req_valid && !err_cut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      kind_q  <= BK_SINGLE;
      size_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (err_cut) begin
        trans_q <= TR_IDLE;
      end else if (bus_ready) begin
        if (!in_burst) begin
          if (req_valid) begin
            trans_q <= TR_START;
            addr_q  <= req_addr;
            base_q  <= req_addr;
            kind_q  <= req_kind;
            size_q  <= req_size;
          end
        end else if (finish) begin
          trans_q <= TR_IDLE;
          done_q  <= 1'b1;
        end else begin
          if (beat_acc) addr_q <= nxt_addr;
          trans_q <= src_ready ? TR_CONT : TR_PAUSE;
        end
      end
    end
  end

  assign trans_o = trans_q;
  assign addr_o  = addr_q;
  assign base_o  = base_q;
  assign kind_o  = kind_q;
  assign size_o  = size_q;
  assign done_o  = done_q;

  // R6: a stall without error freezes every address-phase output
  p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && !bus_err) |=> ($stable(trans_q) && $stable(addr_q)
                                  && $stable(kind_q) && $stable(size_q)));

  // R2: leaving idle always happens through a start phase
  p_open_with_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_q != TR_IDLE) |-> (($past(trans_q) != TR_IDLE) || (trans_q == TR_START)));

  // R5: an accepted pause phase does not move the address
  p_pause_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_q == TR_PAUSE && bus_ready) |=> $stable(addr_q));

  // R9: error in its first cycle drops to idle with no completion
  p_err_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_ready) |=> (trans_q == TR_IDLE && !done_q));

  // R7: completion pulse only follows an accepting edge and shows idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (trans_q == TR_IDLE && $past(bus_ready)));

  // R4: when the calculator folds the address, the next address is lower
  p_wrap_goes_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && wrap_taken && !finish) |=> (addr_q < $past(addr_q)));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_kind,
  input  logic [2:0]    req_size,
  input  logic          src_ready,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic [1:0]    trans_o,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    kind_o,
  output logic [2:0]    size_o,
  output logic          done_o
);
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] base_addr;
  logic          wrap_taken;
  logic          last_beat;
  logic          beat_acc;
  logic          ctr_clear;
  logic [CW-1:0] beat_count;

  burst_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_size(req_size),
    .src_ready(src_ready), .bus_ready(bus_ready), .bus_err(bus_err),
    .nxt_addr(nxt_addr), .wrap_taken(wrap_taken), .last_beat(last_beat),
    .beat_acc(beat_acc), .ctr_clear(ctr_clear),
    .trans_o(trans_o), .addr_o(addr_o), .base_o(base_addr),
    .kind_o(kind_o), .size_o(size_o), .done_o(done_o)
  );

  burst_addr_calc #(.AW(AW)) u_calc (
    .cur_addr(addr_o), .base_addr(base_addr),
    .kind(kind_o), .size(size_o),
    .nxt_addr(nxt_addr), .wrap_taken(wrap_taken)
  );

  burst_beat_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .clear(ctr_clear), .bump(beat_acc), .kind(kind_o),
    .count(beat_count), .last_beat(last_beat)
  );

  // R7: beat counter never bumps while the sequencer is idle
  p_no_idle_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_o == 2'b00) |-> !beat_acc);

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_kind = '0;
  logic [2:0]    req_size = '0;
  logic          src_ready = 1'b1;
  logic          bus_ready = 1'b1;
  logic          bus_err = 1'b0;
  logic [1:0]    trans_o;
  logic [AW-1:0] addr_o;
  logic [2:0]    kind_o;
  logic [2:0]    size_o;
  logic          done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [AW-1:0] seen [16];

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_size(req_size), .src_ready(src_ready),
    .bus_ready(bus_ready), .bus_err(bus_err), .trans_o(trans_o),
    .addr_o(addr_o), .kind_o(kind_o), .size_o(size_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_len(input logic [2:0] k);
    if (k == 3'b000) return 1;
    return 2 << (k[2:1]);
  endfunction

  // Bench model: offset within the aligned window, advanced modulo its width
  function automatic logic [31:0] exp_next(input logic [31:0] a, input logic [31:0] base,
                                           input logic [2:0] k, input logic [2:0] sz);
    logic [31:0] stp, win, lo;
    stp = 32'd1 << sz;
    if (k != 3'b000 && k[0] == 1'b0) begin
      win = stp * exp_len(k);
      lo  = base - (base % win);
      return lo + ((a - lo + stp) % win);
    end
    return a + stp;
  endfunction

  task automatic run_fixed(input logic [31:0] a0, input logic [2:0] k,
                           input logic [2:0] sz, input string tag);
    logic [31:0] a;
    int n;
    n = exp_len(k);
    req_addr = a0; req_kind = k; req_size = sz; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    check(trans_o == 2'b10 && addr_o == a0, {tag, " R2 start"}, {trans_o, addr_o[29:0]}, {2'b10, a0[29:0]});
    check(kind_o == k && size_o == sz, {tag, " R2 kind/size"}, {kind_o, size_o}, {k, sz});
    seen[0] = addr_o;
    a = a0;
    for (int i = 1; i < n; i++) begin
      a = exp_next(a, a0, k, sz);
      step();
      seen[i] = addr_o;
      check(trans_o == 2'b11 && addr_o == a, {tag, " beat"}, addr_o, a);
    end
    step();
    check(trans_o == 2'b00 && done_o, {tag, " R7 end"}, {trans_o, done_o}, 3'b001);
    step();
    check(!done_o, {tag, " R7 pulse width"}, done_o, 0);
  endtask

  task automatic t_reset();
    check(trans_o == 2'b00 && !done_o, "R1 reset", {trans_o, done_o}, 0);
  endtask

  task automatic t_incr4();
    run_fixed(32'h10, 3'b011, 3'd2, "R3 incr4");
    check(seen[0] == 32'h10 && seen[1] == 32'h14 && seen[2] == 32'h18 && seen[3] == 32'h1C,
          "R3 incr4 list", seen[3], 32'h1C);
  endtask

  task automatic t_wraps();
    run_fixed(32'h14, 3'b010, 3'd2, "R4 wrap4");
    check(seen[0] == 32'h14 && seen[1] == 32'h18 && seen[2] == 32'h1C && seen[3] == 32'h10,
          "R4 wrap4 list", seen[3], 32'h10);
    run_fixed(32'h36, 3'b100, 3'd1, "R4 wrap8 half");
    check(seen[5] == 32'h30 && seen[7] == 32'h34, "R4 wrap8 fold", seen[5], 32'h30);
    run_fixed(32'h1F8, 3'b110, 3'd0, "R4 wrap16 byte");
    run_fixed(32'h400, 3'b111, 3'd3, "R3 incr16 dword");
    run_fixed(32'h7C, 3'b101, 3'd2, "R3 incr8 word");
  endtask

  task automatic t_single();
    run_fixed(32'h100, 3'b000, 3'd2, "R10 single");
  endtask

  task automatic t_pause();
    int beats;
    req_addr = 32'h40; req_kind = 3'b011; req_size = 3'd2; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    src_ready = 1'b0;
    step();
    check(trans_o == 2'b01 && addr_o == 32'h44, "R5 pause shows next", addr_o, 32'h44);
    step();
    check(trans_o == 2'b01 && addr_o == 32'h44, "R5 pause held", {trans_o, addr_o[29:0]}, {2'b01, 30'h44});
    src_ready = 1'b1;
    step();
    check(trans_o == 2'b11 && addr_o == 32'h44, "R5 resume continue", {trans_o, addr_o[29:0]}, {2'b11, 30'h44});
    beats = 2;
    while (trans_o != 2'b00 && beats < 10) begin
      step();
      if (trans_o == 2'b11) beats++;
    end
    check(beats == 4 && done_o, "R5 pause not counted", beats, 4);
    step();
  endtask

  task automatic t_stall();
    req_valid = 1'b1;
    bus_ready = 1'b0;
    req_addr = 32'h80; req_kind = 3'b011; req_size = 3'd2;
    step();
    check(trans_o == 2'b00, "R6 no start while stalled", trans_o, 0);
    bus_ready = 1'b1;
    step();
    req_valid = 1'b0;
    bus_ready = 1'b0;
    src_ready = 1'b0;
    step();
    step();
    check(trans_o == 2'b10 && addr_o == 32'h80 && kind_o == 3'b011,
          "R6 frozen", {trans_o, addr_o[29:0]}, {2'b10, 30'h80});
    src_ready = 1'b1;
    bus_ready = 1'b1;
    step();
    check(trans_o == 2'b11 && addr_o == 32'h84, "R6 resume", addr_o, 32'h84);
    step(); step(); step();
    check(trans_o == 2'b00 && done_o, "R7 after stall", {trans_o, done_o}, 1);
    step();
  endtask

  task automatic t_open();
    req_addr = 32'h200; req_kind = 3'b001; req_size = 3'd2; req_valid = 1'b1;
    step();
    check(trans_o == 2'b10 && addr_o == 32'h200, "R8 start", addr_o, 32'h200);
    for (int i = 1; i < 20; i++) begin
      step();
      check(trans_o == 2'b11 && addr_o == 32'h200 + 4 * i, "R8 continue", addr_o, 32'h200 + 4 * i);
    end
    req_valid = 1'b0;
    step();
    check(trans_o == 2'b00 && done_o, "R8 stop on drop", {trans_o, done_o}, 1);
    step();
  endtask

  task automatic t_error();
    req_addr = 32'h300; req_kind = 3'b011; req_size = 3'd2; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    step();
    bus_ready = 1'b0; bus_err = 1'b1;
    step();
    check(trans_o == 2'b00 && !done_o, "R9 abandon", {trans_o, done_o}, 0);
    bus_ready = 1'b1;
    step();
    bus_err = 1'b0;
    check(trans_o == 2'b00 && !done_o, "R9 stays idle", {trans_o, done_o}, 0);
    step();
    check(trans_o == 2'b00, "R9 no resume", trans_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_incr4();
    t_wraps();
    t_single();
    t_pause();
    t_stall();
    t_open();
    t_error();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule